// File: doc/BRIEF.md
# Four-Level Prioritised Interrupt Controller

This block collects the interrupt flags of a small 8-bit microcontroller and turns them into one request with a vector index for the CPU core. The flags are the two external pins, three timers, the serial port (receive and transmit), SPI, the keyboard scanner and the capture/compare array. Some flags are merged before arbitration: the serial port raises one request for either of its flags, and timer 2 raises one request for either overflow or its external event. That leaves nine sources.

Software sets up the block through a byte-wide write port. The settings are a per-source enable, one global enable, and a two-bit priority level for each source. Each level is built from one bit in a low priority register and one bit in a high priority register. The highest eligible level wins. Within a level, a fixed polling order breaks ties, and that position is the vector index.

A four-bit in-service mask tracks nested handlers. A request is offered only when its level is strictly above every level currently in service. The CPU acknowledges an offered request, which marks the level as in service. It signals return from interrupt, which retires the highest in-service level.

Top module: `prio_irq_ctrl`

## Requirements
- R1: After reset, `irq_valid` stays low even with every flag raised, because all enables, the global enable, both priority registers and the in-service mask reset to zero.
- R2: A write with `wr_en` high stores `wr_data` by `wr_addr`:
  - address 0 holds the enables for vector 0..7 in bits 0..7.
  - address 1 holds the enable for vector 8 in bit 0 and the global enable in bit 7.
  - addresses 2 and 3 hold the low priority bits in the same layout as the enables, with bit 7 of address 3 unused.
  - addresses 4 and 5 hold the high priority bits in the same layout.
  - other addresses have no effect.
- R3: `flag_in` bit positions are 0 ext0, 1 ext1, 2 timer0, 3 timer1, 4 timer2 overflow, 5 timer2 external, 6 serial receive, 7 serial transmit, 8 SPI, 9 keyboard, 10 capture/compare. The serial request is bit 6 OR bit 7, and the timer 2 request is bit 4 OR bit 5.
- R4: A source can raise a request only while its own enable and the global enable are both set. With the global enable clear, nothing is requested.
- R5: A source's level is {high bit, low bit}, and level 3 is the highest. The highest-level eligible source wins.
- R6: Among eligible sources of equal level, the one earliest in the order ext0, timer0, ext1, timer1, serial, timer2, capture/compare, keyboard, SPI wins. `irq_vec` is that position, 0 to 8.
- R7: A request is offered only if its level is strictly higher than the highest level in the in-service mask. Requests at an equal or lower level wait.
- R8: A flag raised at a clock edge's input is offered at `irq_valid` two edges later. While `irq_valid` is high without `irq_ack`, `irq_valid` and `irq_vec` hold their values.
- R9: `irq_ack` with `irq_valid` high sets the offered level's bit in the in-service mask and drops `irq_valid` on the next cycle. A pulse on `irq_reti` clears the highest set bit of the mask.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 3 | Register address |
| wr_data | input | 8 | Register write data |
| flag_in | input | 11 | Peripheral and pin interrupt flags |
| irq_ack | input | 1 | CPU accepts the offered interrupt |
| irq_reti | input | 1 | CPU returns from the current handler |
| irq_valid | output | 1 | An interrupt is offered |
| irq_vec | output | 4 | Vector index of the offered interrupt |

## Verification
The assertions assume the following about the inputs:
- `irq_ack` is asserted only while `irq_valid` is high.
- `irq_ack` and `irq_reti` never coincide.
- `irq_reti` is pulsed only when a handler is actually in service.

The bench drives acknowledges only after it has seen a request offered, and it gives each return its own cycle. Before it changes the configuration, it clears the flags and acknowledges any pending request, so that no offer is left dangling.

// File: rtl/prio_irq_pkg.sv
package prio_irq_pkg;
  localparam int NSRC  = 9;
  localparam int NLVL  = 4;
  localparam int LVLW  = $clog2(NLVL);
  localparam int VECW  = $clog2(NSRC + 1);
  localparam int NFLAG = 11;
  localparam int DATAW = 8;
  localparam int ADDRW = 3;

  typedef struct packed {
    logic            gen;
    logic [NSRC-1:0] en;
    logic [NSRC-1:0] plo;
    logic [NSRC-1:0] phi;
  } irq_cfg_t;
endpackage

// File: rtl/prio_irq_regs.sv
module prio_irq_regs
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADDRW-1:0] wr_addr,
  input  logic [DATAW-1:0] wr_data,
  output irq_cfg_t         cfg
);
  localparam int HI = NSRC - DATAW;

  irq_cfg_t cfg_q, cfg_d;

  always_comb begin
    cfg_d = cfg_q;
    if (wr_en) begin
      unique case (wr_addr)
        3'd0: cfg_d.en[DATAW-1:0]     = wr_data;
        3'd1: begin
          cfg_d.en[NSRC-1:DATAW]      = wr_data[HI-1:0];
          cfg_d.gen                   = wr_data[DATAW-1];
        end
        3'd2: cfg_d.plo[DATAW-1:0]    = wr_data;
        3'd3: cfg_d.plo[NSRC-1:DATAW] = wr_data[HI-1:0];
        3'd4: cfg_d.phi[DATAW-1:0]    = wr_data;
        3'd5: cfg_d.phi[NSRC-1:DATAW] = wr_data[HI-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cfg_q <= '0;
    else        cfg_q <= cfg_d;
  end

  assign cfg = cfg_q;
endmodule

// File: rtl/prio_irq_reqmap.sv
module prio_irq_reqmap
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NFLAG-1:0] flag_in,
  output logic [NSRC-1:0]  req
);
  logic [NSRC-1:0] raw, req_q;

  // Poll order: ext0, t0, ext1, t1, serial, t2, cca, kbd, spi
  always_comb begin
    raw[0] = flag_in[0];
    raw[1] = flag_in[2];
    raw[2] = flag_in[1];
    raw[3] = flag_in[3];
    raw[4] = flag_in[6] | flag_in[7];
    raw[5] = flag_in[4] | flag_in[5];
    raw[6] = flag_in[10];
    raw[7] = flag_in[9];
    raw[8] = flag_in[8];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) req_q <= '0;
    else        req_q <= raw;
  end

  assign req = req_q;
endmodule

// File: rtl/prio_irq_arb.sv
module prio_irq_arb
  import prio_irq_pkg::*;
(
  input  logic [NSRC-1:0] req,
  input  irq_cfg_t        cfg,
  input  logic [NLVL-1:0] isr,
  output logic            cand,
  output logic [VECW-1:0] cand_vec,
  output logic [LVLW-1:0] cand_lvl
);
  logic [NSRC-1:0] elig;
  logic [NLVL-1:0] lvl_hit;
  logic [VECW-1:0] lvl_vec [NLVL];

  assign elig = req & cfg.en & {NSRC{cfg.gen}};

  for (genvar l = 0; l < NLVL; l++) begin : g_lvl
    logic [NSRC-1:0] at_lvl;
    for (genvar s = 0; s < NSRC; s++) begin : g_src
      assign at_lvl[s] = elig[s] && ({cfg.phi[s], cfg.plo[s]} == LVLW'(l));
    end
    always_comb begin
      lvl_vec[l] = '0;
      for (int s = NSRC - 1; s >= 0; s--)
        if (at_lvl[s]) lvl_vec[l] = VECW'(s);
    end
    assign lvl_hit[l] = (|at_lvl) && ((isr >> l) == '0);
  end

  always_comb begin
    cand     = 1'b0;
    cand_vec = '0;
    cand_lvl = '0;
    for (int l = 0; l < NLVL; l++) begin
      if (lvl_hit[l]) begin
        cand     = 1'b1;
        cand_vec = lvl_vec[l];
        cand_lvl = LVLW'(l);
      end
    end
  end
endmodule

// File: rtl/prio_irq_ctrl.sv
module prio_irq_ctrl
  import prio_irq_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [ADDRW-1:0] wr_addr,
  input  logic [DATAW-1:0] wr_data,
  input  logic [NFLAG-1:0] flag_in,
  input  logic             irq_ack,
  input  logic             irq_reti,
  output logic             irq_valid,
  output logic [VECW-1:0]  irq_vec
);
  irq_cfg_t        cfg;
  logic [NSRC-1:0] req;
  logic            cand;
  logic [VECW-1:0] cand_vec;
  logic [LVLW-1:0] cand_lvl;

  logic            valid_q, valid_d;
  logic [VECW-1:0] vec_q, vec_d;
  logic [LVLW-1:0] lvl_q, lvl_d;
  logic [NLVL-1:0] isr_q, isr_d;
  logic            load_en;

  prio_irq_regs u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .cfg(cfg)
  );

  prio_irq_reqmap u_map (
    .clk(clk), .rst_n(rst_n), .flag_in(flag_in), .req(req)
  );

  prio_irq_arb u_arb (
    .req(req), .cfg(cfg), .isr(isr_q), .cand(cand),
    .cand_vec(cand_vec), .cand_lvl(cand_lvl)
  );

  assign load_en = !valid_q && cand;

  always_comb begin
    valid_d = valid_q;
    vec_d   = vec_q;
    lvl_d   = lvl_q;
    isr_d   = isr_q;
    if (irq_reti) begin
      for (int l = 0; l < NLVL; l++)
        if (isr_q[l] && ((isr_q >> (l + 1)) == '0)) isr_d[l] = 1'b0;
    end
    if (valid_q && irq_ack) begin
      valid_d       = 1'b0;
      isr_d[lvl_q]  = 1'b1;
    end else if (load_en) begin
      valid_d = 1'b1;
      vec_d   = cand_vec;
      lvl_d   = cand_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      vec_q   <= '0;
      lvl_q   <= '0;
      isr_q   <= '0;
    end else begin
      valid_q <= valid_d;
      vec_q   <= vec_d;
      lvl_q   <= lvl_d;
      isr_q   <= isr_d;
    end
  end

  assign irq_valid = valid_q;
  assign irq_vec   = vec_q;
endmodule

// File: rtl/prio_irq_chk.sv
module prio_irq_chk
  import prio_irq_pkg::*;
(
  input logic            clk,
  input logic            rst_n,
  input logic            irq_ack,
  input logic            irq_reti,
  input logic            irq_valid,
  input logic [VECW-1:0] irq_vec,
  input logic            gen,
  input logic [NLVL-1:0] isr,
  input logic [LVLW-1:0] lvl
);
  // R8
  hold_offer_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && !irq_ack |=> irq_valid && $stable(irq_vec));

  // R6
  vec_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> irq_vec < VECW'(NSRC));

  // R4
  global_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gen && !irq_valid |=> !irq_valid);

  // R7
  strict_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid |-> (isr >> lvl) == '0);

  // R9
  ack_marks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_valid && irq_ack && !irq_reti |=> !irq_valid && isr[$past(lvl)]);

  // R9
  reti_pops_chk: assert property (@(posedge clk) disable iff (!rst_n)
    irq_reti && !irq_ack && isr != '0 |=> $countones(isr) == $countones($past(isr)) - 1);
endmodule

bind prio_irq_ctrl prio_irq_chk u_chk (
  .clk(clk), .rst_n(rst_n), .irq_ack(irq_ack), .irq_reti(irq_reti),
  .irq_valid(irq_valid), .irq_vec(irq_vec), .gen(cfg.gen),
  .isr(isr_q), .lvl(lvl_q)
);

// File: tb/tb_prio_irq_ctrl.sv
`timescale 1ns/1ps
module tb_prio_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [10:0] flag_in = '0;
  logic        irq_ack = 1'b0;
  logic        irq_reti = 1'b0;
  logic        irq_valid;
  logic [3:0]  irq_vec;

  int checks = 0;
  int errors = 0;

  logic [8:0] m_en, m_plo, m_phi;
  logic       m_gen;
  logic [3:0] m_isr;

  always #4 clk = ~clk;

  prio_irq_ctrl dut (.*);

  initial begin
    #1600000;
    errors++; checks++;
    $display("FAIL watchdog: actual=hung expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  task automatic step(int n = 1);
    repeat (n) @(posedge clk);
    #2;
  endtask

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(logic [2:0] a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    step();
    wr_en = 1'b0;
  endtask

  task automatic cfg_all(logic [8:0] en, logic g, logic [8:0] pl, logic [8:0] ph);
    wr(3'd0, en[7:0]); wr(3'd1, {g, 6'd0, en[8]});
    wr(3'd2, pl[7:0]); wr(3'd3, {7'd0, pl[8]});
    wr(3'd4, ph[7:0]); wr(3'd5, {7'd0, ph[8]});
    m_en = en; m_gen = g; m_plo = pl; m_phi = ph;
  endtask

  function automatic logic [8:0] raw_of(logic [10:0] f);
    return {f[8], f[9], f[10], f[4] | f[5], f[6] | f[7], f[3], f[1], f[2], f[0]};
  endfunction

  // returns {valid, vec}
  function automatic logic [4:0] model(logic [10:0] f);
    logic [8:0] e = raw_of(f) & m_en & {9{m_gen}};
    for (int l = 3; l >= 0; l--) begin
      if ((m_isr >> l) != 0) continue;
      for (int s = 0; s < 9; s++)
        if (e[s] && {m_phi[s], m_plo[s]} == 2'(l)) return {1'b1, 4'(s)};
    end
    return 5'd0;
  endfunction

  function automatic int lvl_of(int v);
    return {m_phi[v], m_plo[v]};
  endfunction

  task automatic do_ack(int v);
    irq_ack = 1'b1; flag_in = '0;
    step();
    irq_ack = 1'b0;
    m_isr[lvl_of(v)] = 1'b1;
  endtask

  task automatic do_reti();
    irq_reti = 1'b1;
    step();
    irq_reti = 1'b0;
    for (int l = 3; l >= 0; l--)
      if (m_isr[l]) begin m_isr[l] = 1'b0; break; end
  endtask

  task automatic expect_model(string req);
    logic [4:0] m = model(flag_in);
    chk(req, 8'(irq_valid), 8'(m[4]));
    if (m[4]) chk(req, 8'(irq_vec), 8'(m[3:0]));
  endtask

  initial begin
    logic [4:0] m;
    void'($urandom(32'd20240611));
    m_en = '0; m_gen = 0; m_plo = '0; m_phi = '0; m_isr = '0;
    flag_in = '1;
    step(2);
    rst_n = 1'b1;
    step(3);
    // R1: all flags up, nothing enabled after reset
    chk("R1", 8'(irq_valid), 8'd0);
    flag_in = '0;
    step(2);

    // R4: individual enables set but global clear
    cfg_all(9'h1FF, 1'b0, '0, '0);
    flag_in = '1; step(3);
    chk("R4 global", 8'(irq_valid), 8'd0);
    flag_in = '0; step(2);

    // R3/R6: serial via transmit only; timer2 via external only; ties at level 0
    cfg_all(9'h1FF, 1'b1, '0, '0);
    flag_in = 11'b00000100000; step(2); // timer2 external (bit 5)
    chk("R3 t2ext", {3'd0, irq_valid, irq_vec}, 8'h15);
    do_ack(5); do_reti();
    step(2);
    flag_in = 11'b00010000000; step(2); // serial transmit (bit 7)
    chk("R3 tx", {3'd0, irq_valid, irq_vec}, 8'h14);
    do_ack(4); do_reti();
    step(2);
    // R6: keyboard and SPI tie -> keyboard (vec 7)
    flag_in = 11'b01100000000; step(2);
    chk("R6 tie", {3'd0, irq_valid, irq_vec}, 8'h17);
    do_ack(7); do_reti(); step(2);

    // R2: an unused address writes nothing; R4 per-source mask
    cfg_all(9'h1FE, 1'b1, '0, '0);
    wr(3'd7, 8'hFF);
    flag_in = 11'b00000000001; step(3);
    chk("R2 R4 masked", 8'(irq_valid), 8'd0);
    flag_in = '0; step(2);

    // R8 latency and hold; R5 higher level wins; R7 strict preemption
    cfg_all(9'h1FF, 1'b1, 9'h001, 9'h004); // ext0 level1, ext1 level2
    flag_in = 11'b00000000001;
    step(1);
    chk("R8 latency1", 8'(irq_valid), 8'd0);
    step(1);
    chk("R8 latency2", {3'd0, irq_valid, irq_vec}, 8'h10);
    flag_in = 11'b00000000011; step(3);
    chk("R8 hold", {3'd0, irq_valid, irq_vec}, 8'h10);
    irq_ack = 1'b1; step(); irq_ack = 1'b0; m_isr[1] = 1'b1;
    chk("R9 ack drop", 8'(irq_valid), 8'd0);
    step(1);
    chk("R7 preempt", {3'd0, irq_valid, irq_vec}, 8'h12);
    irq_ack = 1'b1; flag_in = 11'b00000000001; step(); irq_ack = 1'b0; m_isr[2] = 1'b1;
    step(3);
    chk("R7 equal waits", 8'(irq_valid), 8'd0);
    do_reti(); step(2);
    chk("R9 reti top", 8'(irq_valid), 8'd0);
    do_reti(); step(2);
    chk("R9 reti last", {3'd0, irq_valid, irq_vec}, 8'h10);
    do_ack(0); do_reti(); step(2);

    // R5: level 3 keyboard beats level 0 ext0
    cfg_all(9'h1FF, 1'b1, 9'h080, 9'h080);
    flag_in = 11'b01000000001; step(2);
    chk("R5 level", {3'd0, irq_valid, irq_vec}, 8'h17);
    do_ack(7); do_reti(); step(2);

    // Random phase
    for (int it = 0; it < 400; it++) begin
      cfg_all(9'($urandom), ($urandom % 8) != 0, 9'($urandom), 9'($urandom));
      flag_in = 11'($urandom);
      step(2);
      expect_model("R5 R6 R7 rand");
      m = model(flag_in);
      if (m[4]) do_ack(int'(m[3:0]));
      else begin flag_in = '0; step(); end
      step(1);
      if ($urandom % 3 == 0 && m_isr != 0) do_reti();
      step(1);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule